// File: doc/BRIEF.md
# Sector Buffer DRAM Arbiter

This block shares one external byte-wide page-mode DRAM among ten sources: nine external clients and an internal refresh timer. The DRAM holds fixed-size sector frames. Each client raises a request with a frame number, a byte offset inside the frame, a length and a direction. The arbiter picks one winner. It drives the multiplexed row and column address with the RAS/CAS/WE strobes and pulses that client's grant once for each byte moved. A burst stops at the requested length, at sixteen bytes, or at the end of a DRAM row, whichever comes first. The client then asks again for any bytes that remain.

Client 0 is the disc front-end, clients 1 to 7 are the other streaming engines, and the highest-numbered client is the microcontroller. The microcontroller is a static design and has no wait input. While its access is outstanding, the block holds its clock-enable low, so the processor simply freezes until its byte has been read or written.

Top module: `dbuf_arb`

## Requirements
- R1: While reset is applied and right after it, ras_n, cas_n and we_n are high, no grant is asserted and cpu_clk_en is high.
- R2: Only one client holds a grant at a time. A pending refresh goes first. Among waiting clients, the lowest index wins.
- R3: The byte address is frame × 3072 + offset, taken modulo 2^AW. The upper AW/2 bits are on dram_addr when RAS falls. The lower AW/2 bits are on dram_addr while CAS is low.
- R4: A new access holds RAS low for exactly 3 clocks before CAS first falls.
- R5: Each byte takes 2 clocks. CAS is low for one clock, and that is the clock in which gnt and last are valid. CAS is then high for one clock. RAS stays low for the whole burst.
- R6: A burst moves min(length, 16, bytes up to and including column all-ones) bytes, with last asserted alongside the final grant. A length of 0 moves one byte.
- R7: On a write, we_n is low and dq_oe is high in the CAS-low clock, and dq_o carries the client's wdata byte. On a read, rdata holds the DRAM byte in the grant clock.
- R8: After every access, RAS and CAS stay high for at least 2 clocks. Between two back-to-back client bursts, RAS is high for exactly 3 clocks.
- R9: Refresh is requested every 528 clocks and runs as CAS-before-RAS: CAS falls with RAS high, and RAS falls one clock later. With no client traffic, successive refreshes start 528 clocks apart.
- R10: cpu_clk_en goes low in the clock after the microcontroller request rises. It stays low through the grant clock of its last byte and is high again in the following clock.
- R11: If the microcontroller requests while another client's burst is running, it is served next, ahead of every other client. Only refresh may go before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NC | Request per client, held until its last grant |
| wr | input | NC | Direction per client, 1 = write |
| frame | input | NC*FW | Frame number per client |
| offset | input | NC*OW | Byte offset in frame per client (0..3071) |
| len | input | NC*LW | Requested byte count per client |
| wdata | input | NC*8 | Write byte per client |
| gnt | output | NC | One-clock grant per byte moved |
| last | output | 1 | Marks the final grant of a burst |
| rdata | output | 8 | Read byte, valid with a read grant |
| cpu_clk_en | output | 1 | Clock-enable for the microcontroller |
| dram_addr | output | AW/2 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| dq_o | output | 8 | Data to DRAM |
| dq_oe | output | 1 | Drive enable for dq_o |
| dq_i | input | 8 | Data from DRAM |

## Verification
When a client wins in the idle state, RAS falls one clock later. The first grant comes 3 clocks after RAS falls, and each further grant follows 2 clocks after the one before. A written byte lands in the DRAM model at the clock edge that closes the grant clock, so the bench waits one more clock before it reads the model. The bench drives and samples 1 ns after each falling clock edge. It timestamps RAS and CAS edges at those points, so the gaps it compares (3, 2, 3 and 528 clocks) count whole clocks. cpu_clk_en is checked in the clock right after the request, in the grant clock, and in the clock after the grant.

// File: rtl/dbuf_arb.sv
module dbuf_arb #(
  parameter int NC      = 9,
  parameter int AW      = 18,
  parameter int FW      = 11,
  parameter int OW      = 12,
  parameter int LW      = 5,
  parameter int BURST   = 16,
  parameter int RAS_CLK = 3,
  parameter int PRE_CLK = 2,
  parameter int REF_PER = 528
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    req,
  input  logic [NC-1:0]    wr,
  input  logic [NC*FW-1:0] frame,
  input  logic [NC*OW-1:0] offset,
  input  logic [NC*LW-1:0] len,
  input  logic [NC*8-1:0]  wdata,
  output logic [NC-1:0]    gnt,
  output logic             last,
  output logic [7:0]       rdata,
  output logic             cpu_clk_en,
  output logic [AW/2-1:0]  dram_addr,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  input  logic [7:0]       dq_i
);
  localparam int CW  = AW / 2;
  localparam int IW  = $clog2(NC);
  localparam int PW  = FW + OW + 2;
  localparam int RW  = $clog2(REF_PER);
  localparam int TW  = $clog2(RAS_CLK + PRE_CLK + 1);
  localparam logic [IW-1:0] CPU = IW'(NC - 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_CASH, S_PRE, S_CBR} st_t;

  st_t            st;
  logic [TW-1:0]  cnt;
  logic [IW-1:0]  cur;
  logic           cur_wr;
  logic [CW-1:0]  row, col;
  logic [LW-1:0]  rem;
  logic [RW-1:0]  ref_cnt;
  logic           ref_pend, cpu_prio, cpu_pend, cpu_req_q;

  logic           pick_ok;
  logic [IW-1:0]  pick;
  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NC - 1; i >= 0; i--)
      if (req[i]) begin
        pick_ok = 1'b1;
        pick    = IW'(i);
      end
    if (cpu_prio && req[CPU]) pick = CPU;
  end

  logic [FW-1:0] fr_sel;
  logic [OW-1:0] of_sel;
  logic [LW-1:0] ln_sel, ln_clamp;
  logic [AW-1:0] phys;
  assign fr_sel   = frame[pick*FW +: FW];
  assign of_sel   = offset[pick*OW +: OW];
  assign ln_sel   = len[pick*LW +: LW];
  assign ln_clamp = (ln_sel > LW'(BURST)) ? LW'(BURST) : ln_sel;
  assign phys     = AW'(PW'(fr_sel) * PW'(3072) + PW'(of_sel));

  logic endb;
  assign endb = (rem <= LW'(1)) || (&col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cur <= '0; cur_wr <= 1'b0;
      row <= '0; col <= '0; rem <= '0; ref_cnt <= '0;
      ref_pend <= 1'b0; cpu_prio <= 1'b0; cpu_pend <= 1'b0; cpu_req_q <= 1'b0;
    end else begin
      cpu_req_q <= req[CPU];
      if (gnt[CPU] && last) cpu_pend <= 1'b0;
      else if (req[CPU] && !cpu_req_q) cpu_pend <= 1'b1;

      if (ref_cnt == RW'(REF_PER - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else ref_cnt <= ref_cnt + 1'b1;

      if (st == S_IDLE && !ref_pend && pick_ok && pick == CPU) cpu_prio <= 1'b0;
      else if (st != S_IDLE && cur != CPU && req[CPU]) cpu_prio <= 1'b1;

      case (st)
        S_IDLE:
          if (ref_pend) begin
            ref_pend <= 1'b0; st <= S_CBR; cnt <= '0;
          end else if (pick_ok) begin
            cur <= pick; cur_wr <= wr[pick];
            row <= phys[AW-1:CW]; col <= phys[CW-1:0];
            rem <= ln_clamp; st <= S_ROW; cnt <= '0;
          end
        S_ROW:
          if (cnt == TW'(RAS_CLK - 1)) st <= S_COL;
          else cnt <= cnt + 1'b1;
        S_COL: st <= S_CASH;
        S_CASH: begin
          col <= col + 1'b1;
          rem <= rem - 1'b1;
          cnt <= '0;
          st  <= endb ? S_PRE : S_COL;
        end
        S_PRE:
          if (cnt == TW'(PRE_CLK - 1)) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        S_CBR:
          if (cnt == TW'(RAS_CLK)) begin st <= S_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gnt        = (st == S_COL) ? (NC'(1) << cur) : '0;
  assign last       = (st == S_COL) && endb;
  assign rdata      = dq_i;
  assign cpu_clk_en = !cpu_pend;
  assign dram_addr  = (st == S_ROW) ? row : col;
  assign ras_n      = !(st == S_ROW || st == S_COL || st == S_CASH || (st == S_CBR && cnt != '0));
  assign cas_n      = !(st == S_COL || st == S_CBR);
  assign we_n       = !(st == S_COL && cur_wr);
  assign dq_oe      = (st == S_COL) && cur_wr;
  assign dq_o       = wdata[cur*8 +: 8];
endmodule

// File: rtl/dbuf_arb_chk.sv
module dbuf_arb_chk #(
  parameter int NC    = 9,
  parameter int BURST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NC-1:0] req,
  input logic [NC-1:0] gnt,
  input logic          last,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic          cpu_clk_en
);
  logic [7:0] nb;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nb <= '0;
    else if (ras_n) nb <= '0;
    else if (|gnt) nb <= nb + 1'b1;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2
  AST_GRANT_STROBES: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |-> (!ras_n && !cas_n)); // R5
  AST_RAS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) ($fell(cas_n) && !ras_n) |-> (!$past(ras_n) && !$past(ras_n, 2))); // R4
  AST_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |-> (nb < 8'(BURST))); // R6
  AST_LAST_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n) last |-> (|gnt)); // R6
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (dq_oe && !cas_n && !ras_n)); // R7
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |=> (ras_n && cas_n)); // R8
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ($fell(cas_n) && ras_n) |=> (!ras_n && !cas_n)); // R9
  AST_CPU_STALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(req[NC-1]) |=> !cpu_clk_en); // R10
  AST_CPU_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (gnt[NC-1] && last) |=> cpu_clk_en); // R10
endmodule

bind dbuf_arb dbuf_arb_chk #(.NC(NC), .BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .last(last),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe), .cpu_clk_en(cpu_clk_en)
);

// File: tb/sim_dbuf_arb.sv
module sim_dbuf_arb;
  localparam int NC = 9, AW = 18, FW = 11, OW = 12, LW = 5, CW = AW / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NC-1:0] req = '0, wr = '0;
  logic [NC*FW-1:0] frame = '0;
  logic [NC*OW-1:0] offset = '0;
  logic [NC*LW-1:0] len = '0;
  logic [NC*8-1:0] wdata = '0;
  logic [NC-1:0] gnt;
  logic last, cpu_clk_en, ras_n, cas_n, we_n, dq_oe;
  logic [7:0] rdata, dq_o, dq_i;
  logic [CW-1:0] dram_addr;

  dbuf_arb u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .frame(frame), .offset(offset),
    .len(len), .wdata(wdata), .gnt(gnt), .last(last), .rdata(rdata),
    .cpu_clk_en(cpu_clk_en), .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  logic [7:0] mem [0:(1<<AW)-1];
  logic [CW-1:0] rowl = '0;
  logic ras_p = 1'b1, cas_p = 1'b1;
  always @(posedge clk) begin
    if (!ras_n && cas_n && ras_p) rowl <= dram_addr;
    if (!ras_n && !cas_n && cas_p && !we_n) mem[{rowl, dram_addr}] <= dq_o;
    ras_p <= ras_n;
    cas_p <= cas_n;
  end
  assign dq_i = mem[{rowl, dram_addr}];

  int cyc = 0, t_rf = 0, rf_to_cf = 0, t_cas = 0, cas_gap = 0, t_rr = 0, high_len = 0;
  int row_seen = 0, col_first = 0, nref = 0, t_ref = 0, cbr_bad = 0, nord = 0;
  int order [0:15];
  logic mr_p = 1'b1, mc_p = 1'b1, after_rf = 1'b0, cbr_chk = 1'b0;
  logic [7:0] rbuf [0:NC-1][0:31];

  always @(negedge clk) begin
    cyc++;
    if (cbr_chk) begin
      if (ras_n || cas_n) cbr_bad++;
      cbr_chk = 1'b0;
    end
    if (ras_n && !mr_p) t_rr = cyc;
    if (!ras_n && mr_p && cas_n) begin
      t_rf = cyc; row_seen = int'(dram_addr); high_len = cyc - t_rr; after_rf = 1'b1;
    end
    if (!cas_n && mc_p) begin
      if (ras_n) begin
        nref++; t_ref = cyc; cbr_chk = 1'b1;
      end else begin
        if (after_rf) begin
          rf_to_cf = cyc - t_rf; col_first = int'(dram_addr); after_rf = 1'b0;
        end else cas_gap = cyc - t_cas;
        t_cas = cyc;
      end
    end
    if (|gnt && last)
      for (int i = 0; i < NC; i++)
        if (gnt[i] && nord < 16) begin order[nord] = i; nord++; end
    mr_p = ras_n;
    mc_p = cas_n;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ref;
    int n0;
    n0 = nref;
    while (nref == n0) tick();
  endtask

  task automatic do_burst(input int c, input bit w, input int fr, input int of,
                          input int ln, input logic [7:0] base, output int ng);
    frame[c*FW +: FW]  = FW'(fr);
    offset[c*OW +: OW] = OW'(of);
    len[c*LW +: LW]    = LW'(ln);
    wr[c]              = w;
    wdata[c*8 +: 8]    = base;
    req[c]             = 1'b1;
    ng = 0;
    forever begin
      tick();
      wdata[c*8 +: 8] = base + 8'(ng);
      if (gnt[c]) begin
        if (!w) rbuf[c][ng] = rdata;
        ng++;
        if (last) break;
      end
    end
    req[c] = 1'b0;
  endtask

  task automatic t_reset;
    tick();
    chk("R1 ras_n in reset", int'(ras_n), 1);
    chk("R1 cas_n in reset", int'(cas_n), 1);
    chk("R1 we_n in reset", int'(we_n), 1);
    chk("R1 gnt in reset", int'(gnt), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 cpu_clk_en after reset", int'(cpu_clk_en), 1);
    chk("R1 gnt after reset", int'(gnt), 0);
  endtask

  task automatic t_write_read;
    int ng;
    do_burst(0, 1'b1, 2, 10, 4, 8'h30, ng);
    chk("R6 write of 4 bytes", ng, 4);
    chk("R4 RAS to first CAS clocks", rf_to_cf, 3);
    chk("R5 page byte spacing", cas_gap, 2);
    chk("R3 row of frame 2 offset 10", row_seen, 12);
    chk("R3 column of frame 2 offset 10", col_first, 10);
    tick();
    for (int k = 0; k < 4; k++) chk("R7 written byte", int'(mem[6154 + k]), 'h30 + k);
    do_burst(2, 1'b0, 2, 10, 4, 8'h00, ng);
    chk("R6 read of 4 bytes", ng, 4);
    for (int k = 0; k < 4; k++) chk("R7 read byte", int'(rbuf[2][k]), 'h30 + k);
  endtask

  task automatic t_limits;
    int ng;
    do_burst(3, 1'b1, 0, 510, 8, 8'h50, ng);
    chk("R6 stop at row end", ng, 2);
    do_burst(4, 1'b0, 1, 0, 20, 8'h00, ng);
    chk("R6 stop at 16 bytes", ng, 16);
    do_burst(7, 1'b0, 1, 0, 0, 8'h00, ng);
    chk("R6 zero length moves one byte", ng, 1);
  endtask

  task automatic t_wrap;
    int ng;
    do_burst(5, 1'b1, 85, 1100, 1, 8'hA5, ng);
    tick();
    chk("R3 wrapped address data", int'(mem[76]), 'hA5);
    chk("R3 wrapped row", row_seen, 0);
    chk("R3 wrapped column", col_first, 76);
  endtask

  task automatic t_prio;
    int n1, n2;
    wait_ref();
    nord = 0;
    fork
      do_burst(3, 1'b0, 0, 0, 2, 8'h00, n1);
      do_burst(1, 1'b0, 0, 0, 2, 8'h00, n2);
    join
    chk("R2 lower index served first", order[0], 1);
    chk("R2 higher index served second", order[1], 3);
    chk("R8 RAS high between bursts", high_len, 3);
  endtask

  task automatic cpu_access;
    frame[(NC-1)*FW +: FW]  = FW'(3);
    offset[(NC-1)*OW +: OW] = OW'(5);
    len[(NC-1)*LW +: LW]    = LW'(1);
    wr[NC-1]                = 1'b0;
    req[NC-1]               = 1'b1;
    tick();
    chk("R10 clock held after request", int'(cpu_clk_en), 0);
    while (!gnt[NC-1]) tick();
    chk("R10 clock held in grant clock", int'(cpu_clk_en), 0);
    req[NC-1] = 1'b0;
    tick();
    chk("R10 clock released after grant", int'(cpu_clk_en), 1);
  endtask

  task automatic t_cpu;
    int n1, n2;
    wait_ref();
    nord = 0;
    fork
      do_burst(2, 1'b0, 3, 0, 8, 8'h00, n1);
      begin
        do tick(); while (!gnt[2]);
        fork
          do_burst(6, 1'b0, 3, 0, 1, 8'h00, n2);
          cpu_access();
        join
      end
    join
    chk("R11 running burst first", order[0], 2);
    chk("R11 processor served next", order[1], NC - 1);
    chk("R11 other client after processor", order[2], 6);
  endtask

  task automatic t_refresh;
    int ta;
    wait_ref();
    wait_ref();
    ta = t_ref;
    wait_ref();
    chk("R9 refresh interval", t_ref - ta, 528);
    tick();
    chk("R9 CAS-before-RAS order", cbr_bad, 0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_limits();
    t_wrap();
    t_prio();
    t_cpu();
    t_refresh();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule